// File: doc/BRIEF.md
# Ethernet PHY Management Bus Master

This block runs read and write transactions on the two-wire serial management bus of an Ethernet PHY. A request carries a 5-bit PHY address, a 5-bit register address, a direction and, for writes, a 16-bit value. The block produces the management clock itself and drives the data line through separate data-out, output-enable and data-in signals. The tri-state pad sits outside the block.

Each transaction starts with a preamble of driven ones. A header follows, then a turnaround and a 16-bit data field. On a read, the block checks the first turnaround bit. If no PHY pulls the line low, the block abandons the frame, runs a fixed number of released clock cycles so that any PHY can resynchronise, and reports a no-PHY error instead of data. A parameter gives the management clock half-period as a number of system clock cycles.

Top module: `mdio_master`

## Requirements
- R1: After synchronous reset, busy, done, no_phy_err and rd_data are 0, mdc is 1 and mdio_oe is 0.
- R2: While busy is low, mdc is held high and mdio_oe is low.
- R3: Each transaction begins with PREAMBLE_SLOTS (default 32) mdc cycles during which mdio_oe=1 and mdio_o=1.
- R4: After the preamble, the block drives these header bits in this order: start 0,1; opcode 1,0 for a read (rd_req=1) or 0,1 for a write; phy_addr MSB first; reg_addr MSB first.
- R5: Each mdc low phase and each mdc high phase lasts HALF_CYCLES system clocks. mdio_o and mdio_oe change only while mdc is low. A write therefore completes 130*HALF_CYCLES clocks after the accepting edge.
- R6: A write drives turnaround bits 1,0 and then wr_data MSB first. It then releases the line (mdio_oe=0) for one more mdc cycle before done.
- R7: A read releases the line from the first turnaround bit onward. It samples mdio_i at the end of each mdc high phase. With the first turnaround bit low, the 16 data slots that follow the second turnaround bit are assembled MSB first into rd_data, with no_phy_err=0. One released tail cycle follows, and done comes at the end of it.
- R8: If mdio_i is high at the first turnaround bit of a read, the block issues ABORT_SLOTS (default 32) further released mdc cycles and then completes with no_phy_err=1 and rd_data=0. This takes (47+32)*2*HALF_CYCLES clocks in total.
- R9: A start pulse while busy is ignored, and the frame in progress continues unchanged.
- R10: busy is high from the cycle after an accepted start until done. done is a single-cycle pulse, and busy is low in that cycle.
- R11: no_phy_err stays set until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when idle |
| rd_req | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Write value |
| rd_data | output | 16 | Read result, 0 after a no-PHY error |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| no_phy_err | output | 1 | Last read found no PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line level |

## Verification
The bench builds the block with HALF_CYCLES=3 and the default preamble and abort lengths of 32. Every mdc phase therefore spans several system clocks, so a data-line change during a high phase would be seen. The exact totals of 390 clocks for a complete frame and 474 clocks for an aborted read pin down the slot count of each path. A model PHY drives the turnaround and data slots, or leaves the line pulled high. This exercises both the normal read path and the abort path, and the bench records every slot on rising mdc edges.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = 32;   // start+op+phy+reg+ta+data
  localparam int TA1_POS = 14;   // slot index of first turnaround bit
  localparam int DAT_POS = 16;   // first data slot
  typedef enum logic [1:0] {PH_PRE, PH_FRAME, PH_TAIL, PH_ABORT} phase_t;
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
  parameter int HALF_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  generate
    if (HALF_CYCLES > 1) begin : g_spacing
      assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PREAMBLE_SLOTS = 32,
  parameter int ABORT_SLOTS    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  input  logic              mdio_i,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              busy,
  output logic              done,
  output logic              no_phy_err,
  output logic [DATA_W-1:0] rd_data
);
  localparam int MAX_A = (PREAMBLE_SLOTS > ABORT_SLOTS) ? PREAMBLE_SLOTS : ABORT_SLOTS;
  localparam int MAX_B = (MAX_A > FRAME_W) ? MAX_A : FRAME_W;
  localparam int CW    = $clog2(MAX_B + 1);

  phase_t              ph;
  logic [CW-1:0]       bcnt;
  logic [FRAME_W-1:0]  sh;
  logic                is_rd;
  logic [DATA_W-1:0]   cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_PRE; bcnt <= '0; sh <= '0; is_rd <= 1'b0; cap <= '0;
      mdc <= 1'b1; mdio_o <= 1'b0; mdio_oe <= 1'b0;
      busy <= 1'b0; done <= 1'b0; no_phy_err <= 1'b0; rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          sh         <= {2'b01, rd_req ? 2'b10 : 2'b01, phy_addr, reg_addr, 2'b10, wr_data};
          is_rd      <= rd_req;
          ph         <= PH_PRE;
          bcnt       <= '0;
          mdc        <= 1'b0;
          mdio_o     <= 1'b1;
          mdio_oe    <= 1'b1;
          busy       <= 1'b1;
          no_phy_err <= 1'b0;
        end
      end else if (tick && !mdc) begin
        mdc <= 1'b1;                       // rising edge, line already settled
      end else if (tick) begin             // end of a slot
        mdc <= 1'b0;
        case (ph)
          PH_PRE: begin
            if (bcnt == CW'(PREAMBLE_SLOTS - 1)) begin
              ph <= PH_FRAME; bcnt <= '0; mdio_o <= sh[FRAME_W-1];
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          PH_FRAME: begin
            if (is_rd && bcnt == CW'(TA1_POS) && mdio_i) begin
              ph <= PH_ABORT; bcnt <= '0; mdio_oe <= 1'b0;
            end else begin
              if (is_rd && bcnt >= CW'(DAT_POS)) cap <= {cap[DATA_W-2:0], mdio_i};
              if (bcnt == CW'(FRAME_W - 1)) begin
                ph <= PH_TAIL; mdio_oe <= 1'b0;
              end else begin
                bcnt    <= bcnt + 1'b1;
                sh      <= sh << 1;
                mdio_o  <= sh[FRAME_W-2];
                mdio_oe <= !is_rd || (bcnt < CW'(TA1_POS - 1));
              end
            end
          end
          PH_TAIL: begin
            mdc <= 1'b1; busy <= 1'b0; done <= 1'b1;
            if (is_rd) rd_data <= cap;
          end
          default: begin                  // PH_ABORT
            if (bcnt == CW'(ABORT_SLOTS - 1)) begin
              mdc <= 1'b1; busy <= 1'b0; done <= 1'b1;
              no_phy_err <= 1'b1; rd_data <= '0;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assert_line_stable_high_R5: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  assert_idle_lines_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mdc && !mdio_oe));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_busy_ends_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  assert_err_no_data_R8: assert property (@(posedge clk) disable iff (rst)
    no_phy_err |-> (rd_data == '0));
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(is_rd));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYCLES    = 4,
  parameter int PREAMBLE_SLOTS = 32,
  parameter int ABORT_SLOTS    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              no_phy_err,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic tick;

  mdio_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .run(busy), .tick(tick)
  );

  mdio_frame_seq #(.PREAMBLE_SLOTS(PREAMBLE_SLOTS), .ABORT_SLOTS(ABORT_SLOTS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .tick(tick), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .busy(busy), .done(done), .no_phy_err(no_phy_err), .rd_data(rd_data)
  );
endmodule

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  localparam int H = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, rd_req = 1'b0;
  logic [4:0] phy_addr = '0, reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic busy, done, no_phy_err, mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0, failures = 0;
  int rise_cnt = 0;
  logic rec_oe [0:127];
  logic rec_out[0:127];
  logic phy_present = 1'b0;
  logic [15:0] phy_data = '0;
  logic drv_en = 1'b0, drv_bit = 1'b1;

  always #4 clk = ~clk;   // 125 MHz

  assign mdio_i = mdio_oe ? mdio_o : (drv_en ? drv_bit : 1'b1);

  mdio_master #(.HALF_CYCLES(H)) uut (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .busy(busy), .done(done), .no_phy_err(no_phy_err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // slot recorder
  always @(posedge mdc) begin
    #1;
    if (rise_cnt < 128) begin
      rec_oe[rise_cnt]  = mdio_oe;
      rec_out[rise_cnt] = mdio_o;
    end
    rise_cnt = rise_cnt + 1;
  end

  // model PHY: drives during the slot that begins at this falling edge
  always @(negedge mdc) begin
    if (phy_present && (rise_cnt == 46 || rise_cnt == 47)) begin
      drv_en = 1'b1; drv_bit = 1'b0;
    end else if (phy_present && rise_cnt >= 48 && rise_cnt <= 63) begin
      drv_en = 1'b1; drv_bit = phy_data[63 - rise_cnt];
    end else begin
      drv_en = 1'b0; drv_bit = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compares recorded slots [lo:hi] against the expected frame
  task automatic chk_slots(input string req, input int lo, input int hi,
                           input logic rd, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] w);
    logic [31:0] fr;
    int bad;
    fr = {2'b01, rd ? 2'b10 : 2'b01, p, r, 2'b10, w};
    bad = -1;
    for (int k = lo; k <= hi; k++) begin
      logic eoe, eout;
      if (k < 32) begin eoe = 1'b1; eout = 1'b1; end
      else if (k < 64 && (!rd || k < 46)) begin eoe = 1'b1; eout = fr[63 - k]; end
      else begin eoe = 1'b0; eout = rec_out[k]; end
      if (bad < 0 && (rec_oe[k] !== eoe || rec_out[k] !== eout)) bad = k;
    end
    chk(req, (bad < 0) ? 32'd0 : 32'd1 + 32'(bad), 32'd0);
  endtask

  // runs one transaction; optional second start injected at cycle inj
  task automatic run_txn(input logic rd, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] w, input int inj, output int cyc,
                         output logic busy_ok);
    @(negedge clk);
    rise_cnt = 0; drv_en = 1'b0;
    start = 1'b1; rd_req = rd; phy_addr = p; reg_addr = r; wr_data = w;
    @(posedge clk);
    cyc = 0; busy_ok = 1'b1;
    while (1) begin
      @(negedge clk);
      start = (cyc == inj);
      if (cyc == inj) begin rd_req = ~rd; phy_addr = ~p; reg_addr = ~r; wr_data = ~w; end
      if (done) break;
      if (!busy) busy_ok = 1'b0;
      @(posedge clk);
      cyc++;
    end
    start = 1'b0;
    chk("R10 busy low in done cycle", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R10 done single cycle", {31'd0, done}, 32'd0);
    chk("R2 idle mdc high oe low", {30'd0, mdc, mdio_oe}, 32'b10);
  endtask

  task automatic t_reset;
    chk("R1 reset outputs", {rd_data, 12'd0, busy, done, no_phy_err, 1'b0}, 32'd0);
    chk("R1 reset lines", {30'd0, mdc, mdio_oe}, 32'b10);
  endtask

  task automatic t_write;
    int cyc; logic bok;
    phy_present = 1'b0;
    run_txn(1'b0, 5'h11, 5'h0A, 16'hA55A, -1, cyc, bok);
    chk("R10 busy through write", {31'd0, bok}, 32'd1);
    chk("R5 write duration", 32'(cyc), 32'(130 * H));
    chk("R6 write slot count", 32'(rise_cnt), 32'd65);
    chk_slots("R3 preamble", 0, 31, 1'b0, 5'h11, 5'h0A, 16'hA55A);
    chk_slots("R4 write header", 32, 45, 1'b0, 5'h11, 5'h0A, 16'hA55A);
    chk_slots("R6 write ta, data, release", 46, 64, 1'b0, 5'h11, 5'h0A, 16'hA55A);
    chk("R11 no error after write", {31'd0, no_phy_err}, 32'd0);
  endtask

  task automatic t_read_ok(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    int cyc; logic bok;
    phy_present = 1'b1; phy_data = d;
    run_txn(1'b1, p, r, 16'h0, -1, cyc, bok);
    chk("R7 read data", {16'd0, rd_data}, {16'd0, d});
    chk("R7 read no error", {31'd0, no_phy_err}, 32'd0);
    chk("R7 read duration", 32'(cyc), 32'(130 * H));
    chk_slots("R4 read header", 32, 45, 1'b1, p, r, 16'h0);
    chk_slots("R7 read released", 46, 64, 1'b1, p, r, 16'h0);
  endtask

  task automatic t_read_nophy;
    int cyc; logic bok;
    phy_present = 1'b0;
    run_txn(1'b1, 5'h07, 5'h02, 16'h0, -1, cyc, bok);
    chk("R8 error flag", {31'd0, no_phy_err}, 32'd1);
    chk("R8 no data", {16'd0, rd_data}, 32'd0);
    chk("R8 abort duration", 32'(cyc), 32'(158 * H));
    chk("R8 abort slot count", 32'(rise_cnt), 32'd79);
    chk_slots("R8 abort slots released", 46, 78, 1'b1, 5'h07, 5'h02, 16'h0);
  endtask

  task automatic t_busy_ignore;
    int cyc; logic bok;
    phy_present = 1'b0;
    run_txn(1'b0, 5'h05, 5'h13, 16'h3C96, 100, cyc, bok);
    chk("R9 frame length kept", 32'(cyc), 32'(130 * H));
    chk_slots("R9 frame unchanged", 0, 64, 1'b0, 5'h05, 5'h13, 16'h3C96);
    chk("R9 busy kept", {31'd0, bok}, 32'd1);
  endtask

  task automatic t_err_clear;
    @(negedge clk);
    chk("R11 error held while idle", {31'd0, no_phy_err}, 32'd1);
    rise_cnt = 0; phy_present = 1'b1; phy_data = 16'h1234;
    start = 1'b1; rd_req = 1'b1; phy_addr = 5'h01; reg_addr = 5'h01;
    @(negedge clk);
    start = 1'b0;
    chk("R11 error cleared at start", {31'd0, no_phy_err}, 32'd0);
    while (!done) @(negedge clk);
    chk("R11 following read data", {16'd0, rd_data}, 32'h1234);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write();
    t_read_ok(5'h03, 5'h1F, 16'h8421);
    t_read_ok(5'h1E, 5'h00, 16'hFFFE);
    t_read_nophy();
    t_err_clear();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule